// File: doc/BRIEF.md
# Goal-Directed Mapping Stage Decomposer

This block takes one Boolean function of `NVARS` variables as a full truth table, together with a mask of don't-care points, and a chosen single-variable goal (a variable selector and a polarity bit). It works out how that one variable must be rewritten so that the goal function, applied to the rewritten input, reproduces the original function. There are three kinds of rewrite, each a truth table over the other `NVARS-1` variables. The swap table complements the goal variable. The clear table forces it to 0. The set table forces it to 1. Each table comes with its own don't-care mask, which the next level of a decomposition can use.

The tables are registered, so the outputs reflect the inputs present at the previous rising clock edge. A companion datapath applies the registered stage to a live input vector. It rewrites the goal variable and passes every other variable through unchanged. Feeding its output to the goal function gives the original function at every point that was not a don't-care.

Top module: `gdm_decomposer`

## Requirements
- R1: While `rst_n` is low at a rising edge, all six table outputs become zero on that edge and the stage selects variable 0, so `vec_out` equals `vec_in`.
- R2: The tables reflect `func_tt`, `dc_tt`, `goal_sel` and `goal_inv` as sampled at the previous rising edge and do not move between edges.
- R3: A point whose `dc_tt` bit is 1 is treated as holding the goal's value at that point. With every point a don't-care, all three tables are zero.
- R4: With `goal_inv`=0, `set_tt[k]` is 1 exactly when the function is 1 at both points of pair k.
- R5: With `goal_inv`=0, `clr_tt[k]` is 1 exactly when the function is 0 at both points of pair k.
- R6: With `goal_inv`=0, `perm_tt[k]` is 1 exactly when the function is 1 at the point where the goal variable is 0 and 0 at the point where it is 1.
- R7: With `goal_inv`=1 (goal is the complement), `set_tt` marks pairs that are 0 at both points, `clr_tt` marks pairs that are 1 at both points, and `perm_tt` marks pairs holding 0 where the variable is 0 and 1 where it is 1.
- R8: `perm_dc` equals `set_tt | clr_tt`, `clr_dc` equals `set_tt`, and `set_dc` is always zero.
- R9: No pair index is marked in more than one of `perm_tt`, `clr_tt` and `set_tt`.
- R10: A point index is the binary number with variable x1 as its most significant bit. `goal_sel`=b names bit b of the point index. Pair index k is the point index with bit b removed and the remaining bits kept in order.
- R11: `vec_out` equals `vec_in` in every bit except bit b, which becomes `((x XOR perm) AND NOT clr) OR set`, using the three table entries at the pair index of `vec_in`.
- R12: For every `vec_in` that was not a don't-care, `vec_out[b] XOR goal_inv` equals the function value at `vec_in`, where goal, function and mask are those of the last loaded edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| func_tt | input | 2^NVARS | Function truth table, bit j is the value at point j |
| dc_tt | input | 2^NVARS | Don't-care mask, bit j set marks point j as free |
| goal_sel | input | clog2(NVARS) | Bit position of the goal variable within the point index |
| goal_inv | input | 1 | 0: goal is the variable, 1: goal is its complement |
| perm_tt | output | 2^(NVARS-1) | Swap (complement) table per pair |
| perm_dc | output | 2^(NVARS-1) | Don't-care mask for the swap table |
| clr_tt | output | 2^(NVARS-1) | Force-to-0 table per pair |
| clr_dc | output | 2^(NVARS-1) | Don't-care mask for the force-to-0 table |
| set_tt | output | 2^(NVARS-1) | Force-to-1 table per pair |
| set_dc | output | 2^(NVARS-1) | Don't-care mask for the force-to-1 table, always zero |
| vec_in | input | NVARS | Live input vector for the stage datapath |
| vec_out | output | NVARS | Input vector after the registered stage is applied |

## Verification
The assertions assume that `goal_sel` always names an existing variable, below `NVARS`. The bench only ever drives selectors in that range. They also assume that `rst_n` is low at the first clock edge, which the bench guarantees by holding reset for two cycles before any loading. The don't-care mask is treated as a free input that may overlap any function value, so the stimulus mixes fully cared, partly masked and fully masked tables under both goal polarities and every selector.

// File: rtl/gdm_pkg.sv
package gdm_pkg;

    typedef enum logic [1:0] {
        PK_KEEP  = 2'd0,
        PK_SWAP  = 2'd1,
        PK_CLEAR = 2'd2,
        PK_SET   = 2'd3
    } pair_kind_e;

    // Value of the goal function at a point whose goal variable is xbit.
    function automatic logic goal_at(input logic xbit, input logic inv);
        return xbit ^ inv;
    endfunction

    // lo: value where the goal variable is 0, hi: value where it is 1.
    function automatic pair_kind_e classify(input logic lo, input logic hi,
                                            input logic inv);
        pair_kind_e kind;
        if (lo == hi) begin
            kind = (lo != inv) ? PK_SET : PK_CLEAR;
        end else if (lo != goal_at(1'b0, inv)) begin
            kind = PK_SWAP;
        end else begin
            kind = PK_KEEP;
        end
        return kind;
    endfunction

endpackage

// File: rtl/gdm_pair_index.sv
module gdm_pair_index #(
    parameter int NVARS = 4
) (
    input  logic [$clog2(NVARS)-1:0] sel,
    input  logic [NVARS-2:0]         k,
    output logic [NVARS-1:0]         lo_idx,
    output logic [NVARS-1:0]         hi_idx
);
    logic [NVARS-1:0] wide;
    logic [NVARS-1:0] low_mask;
    logic [NVARS-1:0] upper;

    always_comb begin
        wide     = NVARS'(k);
        low_mask = (NVARS'(1) << sel) - NVARS'(1);
        upper    = (wide & ~low_mask) << 1;
        lo_idx   = upper | (wide & low_mask);
        hi_idx   = lo_idx | (NVARS'(1) << sel);
    end
endmodule

// File: rtl/gdm_pair_unit.sv
module gdm_pair_unit
    import gdm_pkg::*;
(
    input  logic lo_f,
    input  logic hi_f,
    input  logic lo_dc,
    input  logic hi_dc,
    input  logic goal_inv,
    output logic swap,
    output logic clear,
    output logic set
);
    logic       lo_v;
    logic       hi_v;
    pair_kind_e kind;

    always_comb begin
        lo_v  = lo_dc ? goal_at(1'b0, goal_inv) : lo_f;
        hi_v  = hi_dc ? goal_at(1'b1, goal_inv) : hi_f;
        kind  = classify(lo_v, hi_v, goal_inv);
        swap  = (kind == PK_SWAP);
        clear = (kind == PK_CLEAR);
        set   = (kind == PK_SET);
    end
endmodule

// File: rtl/gdm_stage_apply.sv
module gdm_stage_apply #(
    parameter int NVARS = 4
) (
    input  logic [NVARS-1:0]          vec_in,
    input  logic [$clog2(NVARS)-1:0]  sel,
    input  logic [(1<<(NVARS-1))-1:0] swap_tt,
    input  logic [(1<<(NVARS-1))-1:0] clear_tt,
    input  logic [(1<<(NVARS-1))-1:0] set_tt,
    output logic [NVARS-1:0]          vec_out
);
    localparam int KW = NVARS - 1;

    logic [NVARS-1:0] low_mask;
    logic [KW-1:0]    k;
    logic             xg;
    logic             nx;

    always_comb begin
        low_mask = (NVARS'(1) << sel) - NVARS'(1);
        k        = KW'(((vec_in >> 1) & ~low_mask) | (vec_in & low_mask));
        xg       = vec_in[sel];
        nx       = ((xg ^ swap_tt[k]) & ~clear_tt[k]) | set_tt[k];
        vec_out      = vec_in;
        vec_out[sel] = nx;
    end
endmodule

// File: rtl/gdm_decomposer.sv
module gdm_decomposer #(
    parameter int NVARS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [(1<<NVARS)-1:0]        func_tt,
    input  logic [(1<<NVARS)-1:0]        dc_tt,
    input  logic [$clog2(NVARS)-1:0]     goal_sel,
    input  logic                         goal_inv,
    output logic [(1<<(NVARS-1))-1:0]    perm_tt,
    output logic [(1<<(NVARS-1))-1:0]    perm_dc,
    output logic [(1<<(NVARS-1))-1:0]    clr_tt,
    output logic [(1<<(NVARS-1))-1:0]    clr_dc,
    output logic [(1<<(NVARS-1))-1:0]    set_tt,
    output logic [(1<<(NVARS-1))-1:0]    set_dc,
    input  logic [NVARS-1:0]             vec_in,
    output logic [NVARS-1:0]             vec_out
);
    localparam int HALF = 1 << (NVARS - 1);
    localparam int KW   = NVARS - 1;
    localparam int SW   = $clog2(NVARS);

    typedef struct packed {
        logic [HALF-1:0] swap;
        logic [HALF-1:0] clr;
        logic [HALF-1:0] set;
        logic [SW-1:0]   sel;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [HALF-1:0] swap_w;
    logic [HALF-1:0] clr_w;
    logic [HALF-1:0] set_w;

    for (genvar gk = 0; gk < HALF; gk++) begin : g_pair
        logic [NVARS-1:0] lo_idx;
        logic [NVARS-1:0] hi_idx;

        gdm_pair_index #(.NVARS(NVARS)) u_idx (
            .sel    (goal_sel),
            .k      (KW'(gk)),
            .lo_idx (lo_idx),
            .hi_idx (hi_idx)
        );

        gdm_pair_unit u_pair (
            .lo_f     (func_tt[lo_idx]),
            .hi_f     (func_tt[hi_idx]),
            .lo_dc    (dc_tt[lo_idx]),
            .hi_dc    (dc_tt[hi_idx]),
            .goal_inv (goal_inv),
            .swap     (swap_w[gk]),
            .clear    (clr_w[gk]),
            .set      (set_w[gk])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.swap = swap_w;
        st_d.clr  = clr_w;
        st_d.set  = set_w;
        st_d.sel  = goal_sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign perm_tt = st_q.swap;
    assign clr_tt  = st_q.clr;
    assign set_tt  = st_q.set;
    assign perm_dc = st_q.set | st_q.clr;
    assign clr_dc  = st_q.set;
    assign set_dc  = '0;

    gdm_stage_apply #(.NVARS(NVARS)) u_stage (
        .vec_in   (vec_in),
        .sel      (st_q.sel),
        .swap_tt  (st_q.swap),
        .clear_tt (st_q.clr),
        .set_tt   (st_q.set),
        .vec_out  (vec_out)
    );
endmodule

// File: rtl/gdm_decomposer_chk.sv
module gdm_decomposer_chk #(
    parameter int NVARS = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [(1<<NVARS)-1:0]     dc_tt,
    input logic [(1<<(NVARS-1))-1:0] perm_tt,
    input logic [(1<<(NVARS-1))-1:0] clr_tt,
    input logic [(1<<(NVARS-1))-1:0] set_tt,
    input logic [NVARS-1:0]          vec_in,
    input logic [NVARS-1:0]          vec_out,
    input logic [$clog2(NVARS)-1:0]  sel
);
    // Reset clears every table on the following edge.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (perm_tt == '0 && clr_tt == '0 && set_tt == '0));

    // A fully free function needs no rewrite at all.
    p_all_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_tt == '1) |=> ((perm_tt | clr_tt | set_tt) == '0));

    // The three rewrite kinds never claim the same pair.
    p_disjoint_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((perm_tt & clr_tt) | (perm_tt & set_tt) | (clr_tt & set_tt)) == '0);

    // Only the goal variable may differ between stage input and output.
    p_passthrough_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (((vec_out ^ vec_in) & ~(NVARS'(1) << sel)) == '0));

    // With no marks at all, the stage is the identity.
    p_identity_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((perm_tt | clr_tt | set_tt) == '0) |-> (vec_out == vec_in));
endmodule

bind gdm_decomposer gdm_decomposer_chk #(.NVARS(NVARS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dc_tt   (dc_tt),
    .perm_tt (perm_tt),
    .clr_tt  (clr_tt),
    .set_tt  (set_tt),
    .vec_in  (vec_in),
    .vec_out (vec_out),
    .sel     (st_q.sel)
);

// File: tb/test_gdm_decomposer.sv
module test_gdm_decomposer;
    localparam int CLK_PERIOD = 10;
    localparam int NV   = 4;
    localparam int PTS  = 1 << NV;
    localparam int HALF = 1 << (NV - 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PTS-1:0]  func_tt = '0;
    logic [PTS-1:0]  dc_tt = '0;
    logic [1:0]      goal_sel = '0;
    logic            goal_inv = 1'b0;
    logic [NV-1:0]   vec_in = 4'b1011;
    logic [HALF-1:0] perm_tt, perm_dc, clr_tt, clr_dc, set_tt, set_dc;
    logic [NV-1:0]   vec_out;

    int n_run  = 0;
    int n_fail = 0;

    // Model of what the registers hold.
    bit             m_valid = 0;
    logic [PTS-1:0] m_f  = '0;
    logic [PTS-1:0] m_dc = '0;
    int             m_sel = 0;
    bit             m_inv = 0;

    gdm_decomposer #(.NVARS(NV)) i_gdm_decomposer (
        .clk, .rst_n, .func_tt, .dc_tt, .goal_sel, .goal_inv,
        .perm_tt, .perm_dc, .clr_tt, .clr_dc, .set_tt, .set_dc,
        .vec_in, .vec_out
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic void model_tables(output logic [HALF-1:0] sw,
                                         output logic [HALF-1:0] cl,
                                         output logic [HALF-1:0] st);
        sw = '0; cl = '0; st = '0;
        if (m_valid) begin
            for (int k = 0; k < HALF; k++) begin
                int  lo, hi;
                bit  a, c;
                lo = ((k >> m_sel) << (m_sel + 1)) | (k & ((1 << m_sel) - 1));
                hi = lo + (1 << m_sel);
                a  = m_dc[lo] ? m_inv : m_f[lo];
                c  = m_dc[hi] ? !m_inv : m_f[hi];
                if (a == c) begin
                    if (a != m_inv) st[k] = 1'b1;
                    else            cl[k] = 1'b1;
                end else if (a != m_inv) begin
                    sw[k] = 1'b1;
                end
            end
        end
    endfunction

    task automatic compare_all();
        logic [HALF-1:0] sw, cl, st;
        int s, v, k;
        bit x;
        logic [NV-1:0] ev;
        model_tables(sw, cl, st);
        if (!m_valid) begin
            check("R1 reset perm", int'(perm_tt), 0);
            check("R1 reset clr",  int'(clr_tt), 0);
            check("R1 reset set",  int'(set_tt), 0);
            check("R1 reset stage pass", int'(vec_out), int'(vec_in));
            return;
        end
        // Tables (R10 index order is built into the model).
        check(m_inv ? "R7 set table"   : "R4 set table",   int'(set_tt),  int'(st));
        check(m_inv ? "R7 clear table" : "R5 clear table", int'(clr_tt),  int'(cl));
        check(m_inv ? "R7 swap table"  : "R6 swap table",  int'(perm_tt), int'(sw));
        check("R8 swap dc",  int'(perm_dc), int'(st | cl));
        check("R8 clear dc", int'(clr_dc),  int'(st));
        check("R8 set dc",   int'(set_dc),  0);
        s = m_sel;
        v = int'(vec_in);
        k = ((v >> (s + 1)) << s) | (v & ((1 << s) - 1));
        x = vec_in[s];
        if (st[k])      x = 1'b1;
        else if (cl[k]) x = 1'b0;
        else if (sw[k]) x = !x;
        ev = vec_in;
        ev[s] = x;
        check("R10 R11 stage output", int'(vec_out), int'(ev));
        if (!m_dc[v]) check("R12 goal after stage", int'(vec_out[s] ^ m_inv), int'(m_f[v]));
    endtask

    // Drive at a negedge, let one edge load, compare at the next negedge.
    task automatic step(input logic [PTS-1:0] f, input logic [PTS-1:0] dc,
                        input int sel, input bit inv, input logic [NV-1:0] v);
        logic [HALF-1:0] p0, c0, s0;
        p0 = perm_tt; c0 = clr_tt; s0 = set_tt;
        func_tt = f; dc_tt = dc; goal_sel = 2'(sel); goal_inv = inv; vec_in = v;
        #1;
        if (m_valid)
            check("R2 tables hold before edge", int'({p0, c0, s0}),
                  int'({perm_tt, clr_tt, set_tt}));
        @(posedge clk);
        m_valid = rst_n;
        m_f = func_tt; m_dc = dc_tt; m_sel = int'(goal_sel); m_inv = goal_inv;
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [PTS-1:0] var_table(input int b);
        logic [PTS-1:0] t;
        for (int j = 0; j < PTS; j++) t[j] = 1'((j >> b) & 1);
        return t;
    endfunction

    initial begin
        @(negedge clk);
        step(16'hA5C3, '0, 2, 1'b0, 4'b1011);
        step(16'h3C5A, '0, 1, 1'b1, 4'b0110);
        rst_n = 1'b1;
        // Function equal to the goal: nothing to rewrite (R4 R5 R6).
        for (int b = 0; b < NV; b++) begin
            step(var_table(b), '0, b, 1'b0, NV'(b * 5));
            step(~var_table(b), '0, b, 1'b0, NV'(b * 3 + 1));
            step(~var_table(b), '0, b, 1'b1, NV'(b + 7));
        end
        // Constants: all clear, then all set under the inverted goal (R7).
        step('0, '0, 3, 1'b0, 4'b1000);
        step('0, '0, 3, 1'b1, 4'b0001);
        step('1, '0, 0, 1'b1, 4'b0101);
        // R3: every point free leaves no marks.
        step(16'h9F31, '1, 1, 1'b0, 4'b1110);
        step(16'h9F31, '1, 2, 1'b1, 4'b0011);
        // Dense cases over all selectors, polarities and vectors.
        for (int i = 0; i < 400; i++) begin
            logic [PTS-1:0] f, dc;
            f  = PTS'($urandom);
            dc = (i % 3 == 0) ? '0 : PTS'($urandom & $urandom);
            step(f, dc, i % NV, 1'(i / NV), NV'($urandom));
        end
        // Reset again mid-run clears the loaded state (R1).
        rst_n = 1'b0;
        step(16'h1234, '0, 1, 1'b0, 4'b0111);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule